// File: doc/BRIEF.md
# Two-Port Coherence Bus Arbiter

This block sits between two snooping cache controllers and a shared command bus. At any time at most one of the two caches owns the bus. Ownership is shown by a per-port "open" signal. An external arbitration choice, sampled every cycle, says which port may take the bus next. A port that has been granted keeps the bus until its cache signals that its task is complete. The port then releases the bus one cycle later.

While a port is open, its bus request is captured into a command register every cycle and broadcast to both caches. The block also drives a sharing acknowledge to each cache. This acknowledge is a purely combinational function of the peer cache's line state. It tells a requester that the other cache holds a usable copy. Such a copy is one that is neither invalid nor still being filled.

Top module: `cba_arbiter`

## Requirements
- R1: While reset is high, at the next clock edge both open outputs go low and `bus_cmd` goes to 2'd0 (idle).
- R2: An open port whose `doneN` is low at a clock edge is still open after that edge.
- R3: An open port whose `doneN` is high at a clock edge is closed after that edge.
- R4: When both ports are closed at an edge, port 0 opens if `arb_sel` is 2'd1, and port 1 opens if `arb_sel` is 2'd2. The values 2'd0 and 2'd3 leave both ports closed.
- R5: A closed port does not open at an edge where the other port is open, whatever `arb_sel` holds. This includes the edge where the other port is closing.
- R6: `open0` and `open1` are never high in the same cycle.
- R7: After each edge, `bus_cmd` holds the values seen at that edge as follows: `req0` if port 0 was open; otherwise `req1` if port 1 was open; otherwise 2'd0. Commands are encoded 2'd0 idle, 2'd1 read, 2'd2 read-exclusive, 2'd3 invalidate.
- R8: `ack0` is low in the same cycle when `line1` is 3'd0 (invalid) or 3'd4 (fill transient), and high for every other value from 3'd1 to 3'd7.
- R9: `ack1` follows the same rule as R8, but uses `line0`.
- R10: A `doneN` pulse on a closed port has no effect. The port stays closed unless R4 opens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_sel | input | 2 | Arbitration choice: 0 none, 1 port 0, 2 port 1, 3 none |
| done0 | input | 1 | Cache 0 reports its task complete |
| done1 | input | 1 | Cache 1 reports its task complete |
| req0 | input | 2 | Cache 0 bus request |
| req1 | input | 2 | Cache 1 bus request |
| line0 | input | 3 | Cache 0 line state |
| line1 | input | 3 | Cache 1 line state |
| open0 | output | 1 | Port 0 owns the bus |
| open1 | output | 1 | Port 1 owns the bus |
| bus_cmd | output | 2 | Registered broadcast command |
| ack0 | output | 1 | Sharing acknowledge to cache 0 |
| ack1 | output | 1 | Sharing acknowledge to cache 1 |

## Verification
Two functions can fall into the same cycle. The first is the owner's release through `done`. The second is the arbitration choice naming the other port, which would hand the bus straight over. The bench provokes this by holding `arb_sel` on the waiting port while the owner signals completion. It also does so through long random runs with frequent `done` pulses. In that cycle the bench expects the owner to close, the waiting port to stay closed, and `bus_cmd` to still carry the closing owner's last request. The waiting port may open only one cycle later.

// File: rtl/cba_pkg.sv
package cba_pkg;

    localparam int NPORT  = 2;
    localparam int CMD_W  = 2;
    localparam int LINE_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_INV  = 2'd3
    } bus_cmd_t;

    typedef enum logic [LINE_W-1:0] {
        L_INV    = 3'd0,
        L_SHR    = 3'd1,
        L_EXC    = 3'd2,
        L_MOD    = 3'd3,
        L_FILL   = 3'd4,
        L_UPG    = 3'd5,
        L_SWAIT  = 3'd6,
        L_SETTLE = 3'd7
    } line_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE = 2'd0,
        SEL_P0   = 2'd1,
        SEL_P1   = 2'd2,
        SEL_RSV  = 2'd3
    } sel_t;

    // A peer copy counts as usable unless it is absent or still filling.
    function automatic logic peer_usable(line_t s);
        return !(s == L_INV || s == L_FILL);
    endfunction

    // Does the arbitration choice name port idx?
    function automatic logic sel_names(logic [SEL_W-1:0] s, int idx);
        return s == SEL_W'(idx + 1);
    endfunction

endpackage

// File: rtl/cba_grant_cell.sv
module cba_grant_cell
    import cba_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             peer_open,
    input  logic             done,
    output logic             open_q
);
    logic open_d;

    always_comb begin
        if (open_q)
            open_d = !done;
        else
            open_d = !peer_open && sel_names(sel, IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= open_d;
    end
endmodule

// File: rtl/cba_cmd_reg.sv
module cba_cmd_reg
    import cba_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] open_v,
    input  bus_cmd_t         req_p0,
    input  bus_cmd_t         req_p1,
    output bus_cmd_t         cmd_q
);
    bus_cmd_t cmd_d;

    always_comb begin
        unique case (1'b1)
            open_v[0]: cmd_d = req_p0;
            open_v[1]: cmd_d = req_p1;
            default:   cmd_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= CMD_IDLE;
        else     cmd_q <= cmd_d;
    end
endmodule

// File: rtl/cba_ack_gen.sv
module cba_ack_gen
    import cba_pkg::*;
(
    input  line_t peer_state,
    output logic  ack
);
    always_comb ack = peer_usable(peer_state);
endmodule

// File: rtl/cba_arbiter.sv
module cba_arbiter
    import cba_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    arb_sel,
    input  logic                done0,
    input  logic                done1,
    input  logic [CMD_W-1:0]    req0,
    input  logic [CMD_W-1:0]    req1,
    input  logic [LINE_W-1:0]   line0,
    input  logic [LINE_W-1:0]   line1,
    output logic                open0,
    output logic                open1,
    output logic [CMD_W-1:0]    bus_cmd,
    output logic                ack0,
    output logic                ack1
);
    logic [NPORT-1:0] open_v;
    logic [NPORT-1:0] done_v;
    logic [NPORT-1:0] ack_v;
    line_t            line_v [NPORT];
    bus_cmd_t         cmd_q;

    assign done_v    = {done1, done0};
    assign line_v[0] = line_t'(line0);
    assign line_v[1] = line_t'(line1);

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        cba_grant_cell #(.IDX(g)) u_grant (
            .clk       (clk),
            .rst       (rst),
            .sel       (arb_sel),
            .peer_open (open_v[NPORT-1-g]),
            .done      (done_v[g]),
            .open_q    (open_v[g])
        );

        cba_ack_gen u_ack (
            .peer_state (line_v[NPORT-1-g]),
            .ack        (ack_v[g])
        );
    end

    cba_cmd_reg u_cmd (
        .clk    (clk),
        .rst    (rst),
        .open_v (open_v),
        .req_p0 (bus_cmd_t'(req0)),
        .req_p1 (bus_cmd_t'(req1)),
        .cmd_q  (cmd_q)
    );

    assign open0   = open_v[0];
    assign open1   = open_v[1];
    assign ack0    = ack_v[0];
    assign ack1    = ack_v[1];
    assign bus_cmd = cmd_q;
endmodule

// File: rtl/cba_checker.sv
module cba_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] arb_sel,
    input logic       done0,
    input logic       done1,
    input logic [1:0] req0,
    input logic [1:0] req1,
    input logic [2:0] line0,
    input logic [2:0] line1,
    input logic       open0,
    input logic       open1,
    input logic [1:0] bus_cmd,
    input logic       ack0,
    input logic       ack1
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!open0 && !open1 && bus_cmd == 2'd0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (open0 && !done0) |=> open0);

    p_close_r3: assert property (@(posedge clk) disable iff (rst)
        (open1 && done1) |=> !open1);

    p_grant_r4: assert property (@(posedge clk) disable iff (rst)
        (!open0 && !open1 && arb_sel == 2'd2) |=> open1);

    p_block_r5: assert property (@(posedge clk) disable iff (rst)
        (open1 && !open0) |=> !open0);

    p_mutex_r6: assert property (@(posedge clk) disable iff (rst)
        !(open0 && open1));

    p_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        open0 |=> bus_cmd == $past(req0));

    p_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (line1 == 3'd4) |-> !ack0);

    p_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (line0 == 3'd3) |-> ack1);

    p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (!open0 && open1 && done0) |=> !open0);
endmodule

bind cba_arbiter cba_checker u_chk (.*);

// File: tb/tb_cba_arbiter.sv
module tb_cba_arbiter;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] arb_sel;
    logic       done0, done1;
    logic [1:0] req0, req1;
    logic [2:0] line0, line1;
    logic       open0, open1;
    logic [1:0] bus_cmd;
    logic       ack0, ack1;

    always #2.5 clk = ~clk;

    cba_arbiter dut (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference state
    int    m_open0 = 0, m_open1 = 0, m_cmd = 0;
    string tag0 = "R1", tag1 = "R1";

    function automatic string tag_for(int was, int peer, bit dn);
        if (was != 0) return dn ? "R3" : "R2";
        if (peer != 0) return "R5";
        if (dn) return "R10";
        return "R4";
    endfunction

    always @(posedge clk) begin
        int n0, n1, nc;
        if (rst) begin
            n0 = 0; n1 = 0; nc = 0;
            tag0 = "R1"; tag1 = "R1";
        end else begin
            tag0 = tag_for(m_open0, m_open1, done0);
            tag1 = tag_for(m_open1, m_open0, done1);
            if (m_open0 != 0) n0 = done0 ? 0 : 1;
            else              n0 = (m_open1 == 0 && arb_sel == 2'd1) ? 1 : 0;
            if (m_open1 != 0) n1 = done1 ? 0 : 1;
            else              n1 = (m_open0 == 0 && arb_sel == 2'd2) ? 1 : 0;
            if (m_open0 != 0)      nc = int'(req0);
            else if (m_open1 != 0) nc = int'(req1);
            else                   nc = 0;
        end
        m_open0 = n0; m_open1 = n1; m_cmd = nc;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_ack(logic [2:0] peer);
        return (peer == 3'd0 || peer == 3'd4) ? 0 : 1;
    endfunction

    task automatic check_regs();
        chk(tag0, int'(open0), m_open0);
        chk(tag1, int'(open1), m_open1);
        chk("R7", int'(bus_cmd), m_cmd);
        chk("R6", int'(open0 & open1), 0);
    endtask

    task automatic check_acks();
        #1;
        chk("R8", int'(ack0), exp_ack(line1));
        chk("R9", int'(ack1), exp_ack(line0));
    endtask

    // one cycle: at falling edge check registers, drive, check acks
    task automatic step(logic [1:0] s, logic d0, logic d1,
                        logic [1:0] q0, logic [1:0] q1,
                        logic [2:0] l0, logic [2:0] l1);
        @(negedge clk);
        check_regs();
        arb_sel = s; done0 = d0; done1 = d1;
        req0 = q0; req1 = q1; line0 = l0; line1 = l1;
        check_acks();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; arb_sel = 0; done0 = 0; done1 = 0;
        req0 = 0; req1 = 0; line0 = 0; line1 = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(open0), 0);
        chk("R1", int'(open1), 0);
        chk("R1", int'(bus_cmd), 0);
        rst = 1'b0;
        // R4: choice none and reserved keep both closed
        step(2'd0, 0, 0, 2'd1, 2'd2, 3'd0, 3'd4);
        step(2'd3, 0, 0, 2'd1, 2'd2, 3'd1, 3'd2);
        // R10: done on closed ports
        step(2'd0, 1, 1, 2'd3, 2'd3, 3'd3, 3'd5);
        // grant port 0, hold (R2) with changing requests (R7)
        step(2'd1, 0, 0, 2'd1, 2'd2, 3'd6, 3'd7);
        step(2'd2, 0, 0, 2'd2, 2'd1, 3'd4, 3'd0);
        step(2'd2, 0, 0, 2'd3, 2'd1, 3'd0, 3'd4);
        // R5: owner releases while choice names the other port
        step(2'd2, 1, 0, 2'd1, 2'd2, 3'd2, 3'd3);
        step(2'd2, 0, 0, 2'd0, 2'd3, 3'd1, 3'd1);
        step(2'd1, 0, 1, 2'd0, 2'd2, 3'd1, 3'd1);
        step(2'd0, 0, 0, 2'd0, 2'd0, 3'd0, 3'd0);
        step(2'd0, 0, 0, 2'd0, 2'd0, 3'd0, 3'd0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            step(2'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
                 2'($urandom), 2'($urandom), 3'($urandom), 3'($urandom));
        end
        @(negedge clk);
        check_regs();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule